// File: doc/BRIEF.md
# Indirect Register Access Window

This block sits between a host bus that decodes only a 256-byte window and an internal register bus that spans a 512 KB (19-bit byte address) register space. Host accesses to ordinary offsets in the window are passed straight through to the internal register at that word offset. Two window words form an indirect port. The first holds a target address. The second is a data port: a read or write of it is carried out on the internal bus at the stored target, plus a fixed base offset (`REG_BASE`) that locates the internal register map.

The target address is one shared register and keeps its value until the host rewrites it. Software therefore has to issue the address write and the data access as one uninterrupted pair. Repeated data accesses without a new address write all reach the same target. Narrow reads, such as single configuration bytes, are made by software: it does a 32-bit access at the word-aligned offset and shifts the result.

A three-state controller sequences every host request:
- `ST_IDLE` waits for `h_req`. An access to the address port completes locally (IDLE→RESP). An access to the data port or to a direct offset latches the internal target and opens a bus cycle (IDLE→BUS).
- `ST_BUS` holds the internal request until `ib_ack` arrives (BUS→BUS while waiting, BUS→RESP on ready).
- `ST_RESP` returns a one-cycle `h_ack` (RESP→IDLE).

Top module: `ind_reg_window`

## Requirements
- R1: After reset, `h_ack` and `ib_req` are 0 and the stored target address reads back as 0.
- R2: A write to the address port (window word offset `ADDR_OFS`, default byte offset 0x68) stores bits 18:2 of `h_wdata` with bits 1:0 forced to 0. A read of that port returns the stored value zero-extended to 32 bits. Both complete with `h_ack` one cycle after the request edge and raise no internal request.
- R3: An access to the data port (default byte offset 0x6C) issues one internal access at `(stored + REG_BASE) mod 2^19`, with the host's direction and write data and `ib_be` = 4'hF.
- R4: A forwarded access holds the host until `ib_ack`. `h_ack` rises in the cycle after the edge that samples `ib_ack`, and a read returns the `ib_rdata` sampled at that edge. The host therefore sees `h_ack` L+2 cycles after the request, where L is the number of cycles the internal bus waits before acking.
- R5: Any other window offset is forwarded to internal byte address `{h_addr[7:2], 2'b00}`. Host address bits 1:0 are ignored.
- R6: The stored target is shared and persistent. Data-port and direct accesses do not change it, and successive data-port accesses reach the same internal address.
- R7: `h_ack` lasts exactly one cycle. While `ib_req` waits for `ib_ack`, `ib_addr` and `ib_we` stay stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_req | input | 1 | Host request, held until `h_ack` |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 8 | Byte offset inside the host window |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid with `h_ack` |
| h_ack | output | 1 | One-cycle host completion |
| ib_req | output | 1 | Internal bus request |
| ib_we | output | 1 | Internal bus write |
| ib_addr | output | 19 | Internal byte address (word aligned) |
| ib_wdata | output | 32 | Internal write data |
| ib_be | output | 4 | Internal byte enables |
| ib_rdata | input | 32 | Internal read data |
| ib_ack | input | 1 | Internal ready |

## Verification
An address-port access acknowledges one cycle after the request edge. A forwarded access acknowledges L+2 cycles after it, where L is the internal wait the memory model in the bench inserts, swept from 0 to 3. The bench counts falling edges from request to `h_ack` and compares that count with these figures. Read data and the captured internal address, enables and write data are sampled at the falling edge where `h_ack` is seen. The target computation is swept over a set of stored addresses that includes the all-ones value, where the base offset wraps. Direct offsets are swept across the whole window with varying low address bits.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_RESP = 2'd2
    } ibr_state_t;

    typedef enum logic [1:0] {
        TGT_ADDRPORT = 2'd0,
        TGT_DATAPORT = 2'd1,
        TGT_DIRECT   = 2'd2
    } ibr_tgt_t;
endpackage

// File: rtl/ibr_addr_latch.sv
module ibr_addr_latch #(
    parameter int AW = 19,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [AW-1:0] q
);
    logic unused_bits;
    assign unused_bits = ^{wr_data[DW-1:AW], wr_data[1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= {wr_data[AW-1:2], 2'b00};
    end

    // R6
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));
endmodule

// File: rtl/ibr_win_decode.sv
module ibr_win_decode
    import ibr_pkg::*;
#(
    parameter int          HW       = 8,
    parameter int          AW       = 19,
    parameter int unsigned ADDR_OFS = 32'h68,
    parameter int unsigned DATA_OFS = 32'h6C,
    parameter int unsigned REG_BASE = 32'h50000
) (
    input  logic [HW-1:0] offset,
    input  logic [AW-1:0] stored,
    output ibr_tgt_t      kind,
    output logic [AW-1:0] target
);
    localparam logic [HW-3:0] ADDR_WORD = HW'(ADDR_OFS) >> 2;
    localparam logic [HW-3:0] DATA_WORD = HW'(DATA_OFS) >> 2;
    localparam logic [AW-1:0] BASE_W    = AW'(REG_BASE);

    logic unused_lo;
    assign unused_lo = ^offset[1:0];

    always_comb begin
        if (offset[HW-1:2] == ADDR_WORD) begin
            kind   = TGT_ADDRPORT;
            target = '0;
        end else if (offset[HW-1:2] == DATA_WORD) begin
            kind   = TGT_DATAPORT;
            target = stored + BASE_W;
        end else begin
            kind   = TGT_DIRECT;
            target = AW'({offset[HW-1:2], 2'b00});
        end
    end
endmodule

// File: rtl/ind_reg_window.sv
module ind_reg_window
    import ibr_pkg::*;
#(
    parameter int          HW       = 8,
    parameter int          AW       = 19,
    parameter int          DW       = 32,
    parameter int unsigned ADDR_OFS = 32'h68,
    parameter int unsigned DATA_OFS = 32'h6C,
    parameter int unsigned REG_BASE = 32'h50000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_req,
    input  logic          h_we,
    input  logic [HW-1:0] h_addr,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    output logic          h_ack,
    output logic          ib_req,
    output logic          ib_we,
    output logic [AW-1:0] ib_addr,
    output logic [DW-1:0] ib_wdata,
    output logic [DW/8-1:0] ib_be,
    input  logic [DW-1:0] ib_rdata,
    input  logic          ib_ack
);
    ibr_state_t    state, state_nx;
    ibr_tgt_t      kind;
    logic [AW-1:0] stored, target;
    logic          addr_wr;

    ibr_win_decode #(
        .HW(HW), .AW(AW), .ADDR_OFS(ADDR_OFS),
        .DATA_OFS(DATA_OFS), .REG_BASE(REG_BASE)
    ) u_dec (
        .offset(h_addr), .stored(stored), .kind(kind), .target(target)
    );

    assign addr_wr = (state == ST_IDLE) && h_req && h_we && (kind == TGT_ADDRPORT);

    ibr_addr_latch #(.AW(AW), .DW(DW)) u_latch (
        .clk(clk), .rst_n(rst_n), .wr_en(addr_wr), .wr_data(h_wdata), .q(stored)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (h_req) state_nx = (kind == TGT_ADDRPORT) ? ST_RESP : ST_BUS;
            ST_BUS:  if (ib_ack) state_nx = ST_RESP;
            ST_RESP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_rdata  <= '0;
            ib_we    <= 1'b0;
            ib_addr  <= '0;
            ib_wdata <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (h_req) begin
                    if (kind == TGT_ADDRPORT) begin
                        if (!h_we) h_rdata <= {{(DW-AW){1'b0}}, stored};
                    end else begin
                        ib_we    <= h_we;
                        ib_addr  <= target;
                        ib_wdata <= h_wdata;
                    end
                end
                ST_BUS:  if (ib_ack && !ib_we) h_rdata <= ib_rdata;
                ST_RESP: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        h_ack  = (state == ST_RESP);
        ib_req = (state == ST_BUS);
        ib_be  = '1;
    end

    // R7
    ack_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_ack |=> !h_ack);
    // R7
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && !ib_ack) |=> (ib_req && $stable(ib_addr) && $stable(ib_we)));
    // R4
    ack_after_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && ib_ack) |=> (h_ack && !ib_req));
    // R2
    addr_port_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && h_req && kind == TGT_ADDRPORT) |=> (h_ack && !ib_req));
endmodule

// File: tb/sim_ind_reg_window.sv
module sim_ind_reg_window;
    localparam logic [7:0]  AP   = 8'h68;
    localparam logic [7:0]  DP   = 8'h6C;
    localparam logic [18:0] BASE = 19'h50000;

    logic        clk = 0, rst_n = 0;
    logic        h_req = 0, h_we = 0;
    logic [7:0]  h_addr = 0;
    logic [31:0] h_wdata = 0, h_rdata, ib_wdata, ib_rdata = 0;
    logic        h_ack, ib_req, ib_we, ib_ack = 0;
    logic [18:0] ib_addr;
    logic [3:0]  ib_be;

    int checks = 0, errors = 0, lat = 0, bcnt = 0, ib_seen = 0, cycles = 0;
    logic [31:0] mem [int];
    logic [18:0] last_addr;
    logic [3:0]  last_be;
    logic        last_we;

    ind_reg_window u0 (.*);

    always #5 clk = ~clk;

    always @(negedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog R4: run hung, act=%0d cycles exp<100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (ib_req) begin
            ib_seen++;
            if (bcnt == lat) begin
                ib_ack = 1; bcnt = 0;
                last_addr = ib_addr; last_be = ib_be; last_we = ib_we;
                if (ib_we) mem[int'(ib_addr)] = ib_wdata;
                else ib_rdata = mem.exists(int'(ib_addr)) ? mem[int'(ib_addr)] : 32'h0;
            end else begin
                ib_ack = 0; bcnt++;
            end
        end else begin
            ib_ack = 0; bcnt = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic op(input logic we, input logic [7:0] a, input logic [31:0] wd,
                      output logic [31:0] rd, output int cyc);
        @(negedge clk);
        h_req = 1; h_we = we; h_addr = a; h_wdata = wd; cyc = 0;
        do begin @(negedge clk); cyc++; end while (!h_ack && cyc < 50);
        rd = h_rdata;
        h_req = 0;
    endtask

    initial begin
        logic [31:0] rd, exp_v;
        logic [18:0] tgt;
        int cyc, seen0;
        logic [31:0] avals [6] = '{32'h0, 32'h12345, 32'h0003_0007, 32'h7FFFC, 32'hFFFF_FFFF, 32'h0002_FFF0};

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(h_ack == 0 && ib_req == 0, "R1 idle outputs", {30'd0, h_ack, ib_req}, 32'h0);
        @(negedge clk); rst_n = 1;
        op(0, AP, 0, rd, cyc);
        chk(rd == 0, "R1 stored address after reset", rd, 32'h0);

        // R2 address port sweep
        foreach (avals[i]) begin
            seen0 = ib_seen;
            op(1, AP, avals[i], rd, cyc);
            chk(cyc == 1, "R2 write ack timing", cyc, 1);
            op(0, AP + 8'(i % 4), 0, rd, cyc);
            exp_v = avals[i] & 32'h7FFFC;
            chk(rd == exp_v, "R2 readback masked", rd, exp_v);
            chk(cyc == 1 && ib_seen == seen0, "R2 local no bus", ib_seen - seen0, 0);
        end

        // R3/R4 data port sweep with latency
        foreach (avals[i]) begin
            for (int l = 0; l < 4; l++) begin
                lat = l;
                op(1, AP, avals[i], rd, cyc);
                tgt = 19'(avals[i] & 32'h7FFFC) + BASE;
                exp_v = 32'hA500_0000 ^ (32'(i) << 8) ^ 32'(l);
                op(1, DP, exp_v, rd, cyc);
                chk(last_addr == tgt && last_we && last_be == 4'hF, "R3 write target/be",
                    {last_be, 9'd0, last_addr}, {4'hF, 9'd0, tgt});
                chk(mem.exists(int'(tgt)) && mem[int'(tgt)] == exp_v, "R3 write data",
                    mem.exists(int'(tgt)) ? mem[int'(tgt)] : 32'hX, exp_v);
                chk(cyc == l + 2, "R4 write ack latency", cyc, l + 2);
                op(0, DP + 8'(l), 0, rd, cyc);
                chk(rd == exp_v && !last_we, "R4 read data", rd, exp_v);
                chk(cyc == l + 2, "R4 read ack latency", cyc, l + 2);
            end
        end

        // R5 direct offsets across the window
        lat = 1;
        for (int o = 0; o < 256; o += 4) begin
            if (8'(o) == AP || 8'(o) == DP) continue;
            mem[o] = 32'hD000_0000 | 32'(o);
        end
        for (int o = 0; o < 256; o += 4) begin
            if (8'(o) == AP || 8'(o) == DP) continue;
            op(0, 8'(o + (o / 4) % 4), 0, rd, cyc);
            exp_v = 32'hD000_0000 | 32'(o);
            chk(rd == exp_v && last_addr == 19'(o), "R5 direct read", rd, exp_v);
        end
        op(1, 8'h11, 32'hCAFE_0010, rd, cyc);
        chk(last_addr == 19'h10 && mem[16] == 32'hCAFE_0010, "R5 direct write low bits ignored",
            {13'd0, last_addr}, 32'h10);

        // R6 shared address persists across other accesses
        op(1, AP, 32'h0000_4444, rd, cyc);
        tgt = 19'h4444 + BASE;
        op(1, DP, 32'h1111_2222, rd, cyc);
        op(0, 8'h20, 0, rd, cyc);
        op(0, AP, 0, rd, cyc);
        chk(rd == 32'h4444, "R6 address kept", rd, 32'h4444);
        op(0, DP, 0, rd, cyc);
        chk(rd == 32'h1111_2222 && last_addr == tgt, "R6 same target", {13'd0, last_addr}, {13'd0, tgt});
        // byte extraction from a word read: byte 2 of the target word
        chk(((rd >> 16) & 32'hFF) == 32'h11, "R6 byte from word", (rd >> 16) & 32'hFF, 32'h11);

        // R7 ack is a single cycle
        @(negedge clk);
        chk(h_ack == 0 && ib_req == 0, "R7 quiet after ack", {30'd0, h_ack, ib_req}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule